// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Controller

This block supervises the transmit path of a coaxial Ethernet transceiver. Its input is a synchronous "transmit data valid" level. If one transmission runs longer than the jabber limit (nominally 20 ms), a latch sets. The latch gates the transmit driver off and holds the collision oscillator enable high, which reports the fault to the attached station. The latch releases only after the transmit input has stayed quiet for an unbroken reset window (nominally 0.5 s). Any activity inside that window starts the window again.

After each transmission that ends normally, the block produces a heartbeat. The heartbeat is a short collision-enable pulse (nominally 1 µs) that begins a fixed delay (nominally 1.1 µs) after data valid falls. The station uses it as a self-test of the collision path. A strap input turns the heartbeat off. A new transmission that starts while a heartbeat is pending or in progress cancels that heartbeat. Ending a transmission through the jabber latch, or clearing the latch, produces no heartbeat.

All four intervals are parameters in physical units. They are converted to cycle counts from the clock frequency parameter.

Top module: `jabber_hb_ctrl`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first cycle after it is released, txEnable is 1 and colEnable is 0.
- R2: The jabber latch sets (txEnable goes to 0) on the clock edge that samples txValid high for the JAB_CYC-th consecutive time, where JAB_CYC = CLK_HZ*JAB_US/1e6. A transmission of JAB_CYC-1 samples leaves txEnable at 1.
- R3: While the jabber latch is set, colEnable is 1 whatever txValid does.
- R4: The latch clears (txEnable 1, colEnable 0) on the edge that samples txValid low for the UNJAB_CYC-th consecutive time, where UNJAB_CYC = CLK_HZ*UNJAB_US/1e6. After UNJAB_CYC-1 low samples the latch is still set.
- R5: A high sample of txValid during the reset window restarts it, so UNJAB_CYC fresh consecutive low samples are needed after the activity.
- R6: When a transmission ends normally with hbEnable at 1, colEnable stays 0 for HB_DLY_CYC cycles after the first low sample, then is 1 for exactly HB_LEN_CYC cycles. HB_DLY_CYC = CLK_HZ*HB_DLY_NS/1e9 and HB_LEN_CYC = CLK_HZ*HB_LEN_NS/1e9.
- R7: When hbEnable is 0 at the first low sample that ends a transmission, colEnable stays 0 after that transmission.
- R8: A high sample of txValid during the heartbeat delay or pulse cancels the heartbeat. colEnable is 0 after that edge, and only the new transmission's end produces a heartbeat.
- R9: Releasing the jabber latch produces no heartbeat.
- R10: All cycle counts are clamped to a minimum of 1 and are derived only from CLK_HZ and the four interval parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| txValid | input | 1 | Transmit data valid level, synchronous to clk |
| hbEnable | input | 1 | Heartbeat strap, 1 enables the post-transmit pulse |
| txEnable | output | 1 | Transmit driver gate, 0 while the jabber latch is set |
| colEnable | output | 1 | Collision oscillator enable (jabber or heartbeat) |

## Verification
The bench builds the block with CLK_HZ of 10 MHz, a 10 µs jabber limit, a 30 µs reset window and the nominal 1.1 µs and 1 µs heartbeat intervals. These values give 100, 300, 11 and 10 cycles. With counts this small, every edge of each window can be checked cycle by cycle: exactly one sample short of the jabber limit, one sample short of release, and the first and last cycle of the heartbeat pulse. The same settings also make it cheap to cancel a heartbeat both in its delay and in its pulse, and to restart the reset window halfway through.

// File: rtl/jhb_pkg.sv
package jhb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_HB_WAIT,
    ST_HB_PULSE,
    ST_JAB
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic jabRun;
    logic unjabRun;
    logic hbRun;
    logic hbClr;
  } ctrl_strobe_t;

  // terminal-count flags from datapath to control
  typedef struct packed {
    logic jabAtLast;
    logic unjabAtLast;
    logic hbDlyAtLast;
    logic hbLenAtLast;
  } timer_flags_t;

  function automatic int unsigned cycles_of(input longint unsigned hz,
                                            input longint unsigned amount,
                                            input longint unsigned perSec);
    longint unsigned c;
    c = (hz * amount) / perSec;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/jhb_timer.sv
module jhb_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          step,
  input  logic          clr,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN || clr) count <= '0;
    else if (step)    count <= count + 1'b1;
  end

endmodule

// File: rtl/jhb_datapath.sv
module jhb_datapath
  import jhb_pkg::*;
#(
  parameter int unsigned JAB_CYC    = 100,
  parameter int unsigned UNJAB_CYC  = 300,
  parameter int unsigned HB_DLY_CYC = 11,
  parameter int unsigned HB_LEN_CYC = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output timer_flags_t flags
);

  localparam int unsigned HB_MAX = (HB_DLY_CYC > HB_LEN_CYC) ? HB_DLY_CYC : HB_LEN_CYC;
  localparam int JW = $clog2(JAB_CYC + 1);
  localparam int UW = $clog2(UNJAB_CYC + 1);
  localparam int HW = $clog2(HB_MAX + 1);

  localparam logic [JW-1:0] JAB_LAST   = JW'(JAB_CYC - 1);
  localparam logic [UW-1:0] UNJAB_LAST = UW'(UNJAB_CYC - 1);
  localparam logic [HW-1:0] DLY_LAST   = HW'(HB_DLY_CYC - 1);
  localparam logic [HW-1:0] LEN_LAST   = HW'(HB_LEN_CYC - 1);

  logic [JW-1:0] jabCnt;
  logic [UW-1:0] unjabCnt;
  logic [HW-1:0] hbCnt;

  jhb_timer #(.LIMIT(JAB_CYC)) jabTimer_i (
    .clk(clk), .rstN(rstN),
    .step(strobe.jabRun), .clr(!strobe.jabRun), .count(jabCnt)
  );

  jhb_timer #(.LIMIT(UNJAB_CYC)) unjabTimer_i (
    .clk(clk), .rstN(rstN),
    .step(strobe.unjabRun), .clr(!strobe.unjabRun), .count(unjabCnt)
  );

  jhb_timer #(.LIMIT(HB_MAX)) hbTimer_i (
    .clk(clk), .rstN(rstN),
    .step(strobe.hbRun), .clr(strobe.hbClr), .count(hbCnt)
  );

  always_comb begin
    flags.jabAtLast   = (jabCnt == JAB_LAST);
    flags.unjabAtLast = (unjabCnt == UNJAB_LAST);
    flags.hbDlyAtLast = (hbCnt == DLY_LAST);
    flags.hbLenAtLast = (hbCnt == LEN_LAST);
  end

endmodule

// File: rtl/jhb_control.sv
module jhb_control
  import jhb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txValid,
  input  logic         hbEnable,
  input  timer_flags_t flags,
  output ctrl_strobe_t strobe,
  output logic         txEnable,
  output logic         colEnable
);

  ctrl_state_t state, nextState;
  logic jabbed, jabExpire, inHb;

  assign jabbed    = (state == ST_JAB);
  assign inHb      = (state == ST_HB_WAIT) || (state == ST_HB_PULSE);
  assign jabExpire = txValid && !jabbed && flags.jabAtLast;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (txValid) nextState = ST_TX;
      ST_TX:       if (!txValid) nextState = hbEnable ? ST_HB_WAIT : ST_IDLE;
      ST_HB_WAIT:  if (txValid) nextState = ST_TX;
                   else if (flags.hbDlyAtLast) nextState = ST_HB_PULSE;
      ST_HB_PULSE: if (txValid) nextState = ST_TX;
                   else if (flags.hbLenAtLast) nextState = ST_IDLE;
      ST_JAB:      if (!txValid && flags.unjabAtLast) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
    if (jabExpire) nextState = ST_JAB;
  end

  always_comb begin
    strobe.jabRun   = txValid && !jabbed;
    strobe.unjabRun = jabbed && !txValid;
    strobe.hbClr    = (nextState != state);
    strobe.hbRun    = inHb && (nextState == state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign txEnable  = !jabbed;
  assign colEnable = jabbed || (state == ST_HB_PULSE);

endmodule

// File: rtl/jabber_hb_ctrl.sv
module jabber_hb_ctrl
  import jhb_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 20_000_000,
  parameter int unsigned JAB_US    = 20_000,
  parameter int unsigned UNJAB_US  = 500_000,
  parameter int unsigned HB_DLY_NS = 1_100,
  parameter int unsigned HB_LEN_NS = 1_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txValid,
  input  logic hbEnable,
  output logic txEnable,
  output logic colEnable
);

  // R10: interval conversion, each count at least one cycle
  localparam int unsigned JAB_CYC    = cycles_of(CLK_HZ, JAB_US, 1_000_000);
  localparam int unsigned UNJAB_CYC  = cycles_of(CLK_HZ, UNJAB_US, 1_000_000);
  localparam int unsigned HB_DLY_CYC = cycles_of(CLK_HZ, HB_DLY_NS, 1_000_000_000);
  localparam int unsigned HB_LEN_CYC = cycles_of(CLK_HZ, HB_LEN_NS, 1_000_000_000);

  ctrl_strobe_t strobe;
  timer_flags_t flags;

  jhb_datapath #(
    .JAB_CYC(JAB_CYC), .UNJAB_CYC(UNJAB_CYC),
    .HB_DLY_CYC(HB_DLY_CYC), .HB_LEN_CYC(HB_LEN_CYC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(flags)
  );

  jhb_control control_i (
    .clk(clk), .rstN(rstN), .txValid(txValid), .hbEnable(hbEnable),
    .flags(flags), .strobe(strobe), .txEnable(txEnable), .colEnable(colEnable)
  );

endmodule

// File: rtl/jhb_checker.sv
module jhb_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txEnable,
  input logic colEnable
);

  // R1
  property resetOut;
    @(posedge clk) !rstN |=> (txEnable && !colEnable);
  endproperty
  reset_state_chk: assert property (resetOut);

  // R3
  jab_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> colEnable);

  // R2
  jab_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) |-> $past(txValid));

  // R4
  unjab_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> (!$past(txValid) && !colEnable));

  // R8
  hb_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txValid) && txEnable) |-> !colEnable);

endmodule

bind jabber_hb_ctrl jhb_checker chk_i (.*);

// File: tb/jabber_hb_ctrl_tb_top.sv
module jabber_hb_ctrl_tb_top;

  localparam int unsigned CLK_HZ    = 10_000_000;
  localparam int unsigned JAB_US    = 10;
  localparam int unsigned UNJAB_US  = 30;
  localparam int unsigned HB_DLY_NS = 1_100;
  localparam int unsigned HB_LEN_NS = 1_000;
  localparam int J = CLK_HZ / 1_000_000 * JAB_US;    // 100
  localparam int U = CLK_HZ / 1_000_000 * UNJAB_US;  // 300
  localparam int D = CLK_HZ / 1_000_000 * HB_DLY_NS / 1000; // 11
  localparam int L = CLK_HZ / 1_000_000 * HB_LEN_NS / 1000; // 10

  logic clk = 0, rstN = 0, txValid = 0, hbEnable = 1;
  logic txEnable, colEnable;
  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jabber_hb_ctrl #(
    .CLK_HZ(CLK_HZ), .JAB_US(JAB_US), .UNJAB_US(UNJAB_US),
    .HB_DLY_NS(HB_DLY_NS), .HB_LEN_NS(HB_LEN_NS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .txValid(txValid), .hbEnable(hbEnable),
    .txEnable(txEnable), .colEnable(colEnable)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendTx(input int n);
    txValid = 1;
    repeat (n) @(negedge clk);
    txValid = 0;
  endtask

  task automatic watchHb(input bit expectPulse, input string req);
    for (int i = 1; i <= D + L + 3; i++) begin
      @(negedge clk);
      check(req, colEnable, (expectPulse && (i - 1) >= D && (i - 1) < D + L) ? 1 : 0);
      check(req, txEnable, 1);
    end
  endtask

  task automatic t_reset;
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1 txEnable", txEnable, 1);
    check("R1 colEnable", colEnable, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", colEnable, 0);
  endtask

  task automatic t_heartbeat;
    sendTx(20);
    watchHb(1, "R6 R10 heartbeat");
  endtask

  task automatic t_noStrap;
    hbEnable = 0;
    sendTx(20);
    watchHb(0, "R7 strap off");
    hbEnable = 1;
  endtask

  task automatic t_shortOfJab;
    sendTx(J - 1);
    check("R2 one short", txEnable, 1);
    watchHb(1, "R2 normal end");
  endtask

  task automatic t_jab;
    sendTx(J);
    check("R2 jab set", txEnable, 0);
    check("R3 col on", colEnable, 1);
    txValid = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check("R3 held", colEnable, 1);
      check("R3 tx off", txEnable, 0);
    end
    txValid = 0;
    repeat (U - 1) @(negedge clk);
    check("R4 still jabbed", txEnable, 0);
    @(negedge clk);
    check("R4 released tx", txEnable, 1);
    check("R4 released col", colEnable, 0);
    watchHb(0, "R9 no hb after unjab");
  endtask

  task automatic t_unjabRestart;
    sendTx(J);
    check("R5 jabbed", txEnable, 0);
    repeat (U / 2) @(negedge clk);
    txValid = 1;
    repeat (3) @(negedge clk);
    txValid = 0;
    repeat (U - 1) @(negedge clk);
    check("R5 restart held", txEnable, 0);
    check("R5 col held", colEnable, 1);
    @(negedge clk);
    check("R5 released", txEnable, 1);
    watchHb(0, "R9 quiet");
  endtask

  task automatic t_cancel;
    sendTx(20);
    repeat (D / 2) @(negedge clk);
    check("R8 in delay", colEnable, 0);
    sendTx(5);
    watchHb(1, "R8 cancel in delay");
    sendTx(20);
    repeat (D + 3) @(negedge clk);
    check("R8 in pulse", colEnable, 1);
    txValid = 1;
    @(negedge clk);
    check("R8 pulse cut", colEnable, 0);
    repeat (2) @(negedge clk);
    txValid = 0;
    watchHb(1, "R8 cancel in pulse");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_heartbeat();
    t_noStrap();
    t_shortOfJab();
    t_jab();
    t_unjabRestart();
    t_cancel();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule